// File: doc/BRIEF.md
# Challenge-Response Authentication Sequencer

This block answers a host's authentication challenge with a one-byte code derived from two stored 32-bit secrets. The host first writes a selection byte that names which two of four secret words take part. It then writes a four-byte challenge, one byte per write. The write that delivers the fourth byte starts a keyed CRC-32 computation straight away. No separate start command exists.

The computation runs bit-serially. The CRC register is seeded with the first chosen secret. The 32 challenge bits are shifted in, then the 32 bits of the second chosen secret. The final 32-bit remainder is folded into one byte by XOR-ing its four bytes. That byte is placed in a result register and a done flag is raised. A busy flag covers the whole computation. While it is high the result register keeps its previous value and all host writes are dropped.

The secrets are fetched through a narrow read port. The block drives a secret index, and the memory returns the 32-bit word combinationally in the same cycle.

The controller has six states:
- IDLE: waits for a write.
- LOAD: seeds the CRC and captures the challenge.
- SHIFT_CHAL: shifts in the 32 challenge bits.
- FETCH_KEY: fetches the second secret.
- SHIFT_KEY: shifts in the 32 bits of the second secret.
- FINISH: folds and publishes the result.

Its transitions are:
- IDLE→LOAD on the fourth challenge write.
- LOAD→SHIFT_CHAL unconditionally.
- SHIFT_CHAL→FETCH_KEY after the last challenge bit.
- FETCH_KEY→SHIFT_KEY unconditionally.
- SHIFT_KEY→FINISH after the last key bit.
- FINISH→IDLE unconditionally.

Top module: `auth_seq`

## Requirements
- R1: After reset, busy, done and result are all 0.
- R2: A write with wr_reg=0 stores wr_data as the selection byte. Bits [1:0] give the index of the seed secret and bits [3:2] the index of the key secret. Bits [7:4] have no effect on the result.
- R3: A write with wr_reg=1 stores wr_data as the next challenge byte, filling bytes 0, 1, 2, 3 in write order. The first three such writes leave busy low. The fourth raises busy and clears done at the clock edge that captures it.
- R4: The hash is a reflected CRC-32 with polynomial 0xEDB88320, no input or output inversion, seeded with secret[sel[1:0]]. It shifts in challenge bytes 0 to 3 and then the key secret's bytes from bits [7:0] upward. Every byte goes in least significant bit first, one bit per clock.
- R5: The result byte is the XOR of bits [7:0], [15:8], [23:16] and [31:24] of the final CRC value.
- R6: busy stays high for exactly 67 clock cycles. The result and done=1 appear at the edge where busy falls, and done is never high together with busy.
- R7: While busy is high, result keeps the value it had before the computation started.
- R8: Writes of either register while busy is high are ignored. Neither the selection nor the challenge byte count changes.
- R9: A selection write while idle restarts the challenge byte count at byte 0.
- R10: sec_addr shows sel[1:0] in the first busy cycle (LOAD) and sel[3:2] in the 34th busy cycle (FETCH_KEY). The word on sec_data is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_reg | input | 1 | Register select: 0 selection byte, 1 challenge byte |
| wr_data | input | 8 | Host write data |
| sec_addr | output | 2 | Index of the secret word being read |
| sec_data | input | 32 | Secret word for sec_addr, valid in the same cycle |
| result | output | 8 | Authentication code |
| done | output | 1 | High once a result is published, until the next start |
| busy | output | 1 | High while a computation runs |

## Verification
The bench builds the block with its default parameters: a 32-bit CRC, four secret words and four challenge bytes. With these defaults one computation takes only 67 cycles, so the bench can sweep all 16 combinations of seed and key index, each with its own upper-nibble noise and three challenge patterns. Every expected code is recomputed arithmetically with a bit-level CRC model. The small run length also lets each run check the busy window length, the secret index shown in the load and fetch cycles, and the held result at every busy cycle. It also makes room for dedicated runs that write during busy and that interleave a selection write into a partial challenge.

// File: rtl/auth_pkg.sv
package auth_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT_CHAL,
        ST_FETCH_KEY,
        ST_SHIFT_KEY,
        ST_FINISH
    } auth_state_e;

    localparam logic REG_SELECT    = 1'b0;
    localparam logic REG_CHALLENGE = 1'b1;

endpackage

// File: rtl/auth_hostregs.sv
module auth_hostregs #(
    parameter int CHAL_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_reg,
    input  logic [7:0]              wr_data,
    input  logic                    accept,
    output logic [7:0]              sel_q,
    output logic [CHAL_BYTES*8-1:0] chal_q,
    output logic                    start
);
    import auth_pkg::*;

    localparam int CNT_W = (CHAL_BYTES > 1) ? $clog2(CHAL_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAL_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wr_sel_ok;
    logic             wr_chal_ok;

    assign wr_sel_ok  = accept && wr_en && (wr_reg == REG_SELECT);
    assign wr_chal_ok = accept && wr_en && (wr_reg == REG_CHALLENGE);
    assign start      = wr_chal_ok && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            chal_q <= '0;
            cnt_q  <= '0;
        end else if (wr_sel_ok) begin
            sel_q <= wr_data;
            cnt_q <= '0;
        end else if (wr_chal_ok) begin
            chal_q[cnt_q*8 +: 8] <= wr_data;
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/auth_crc_unit.sv
module auth_crc_unit #(
    parameter int            CRC_W = 32,
    parameter logic [31:0]   POLY  = 32'hEDB88320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_en,
    input  logic [CRC_W-1:0] seed_val,
    input  logic             load_en,
    input  logic [CRC_W-1:0] load_val,
    input  logic             shift_en,
    output logic [CRC_W-1:0] crc_q
);
    localparam logic [CRC_W-1:0] POLY_W = POLY[CRC_W-1:0];

    logic [CRC_W-1:0] dat_q;
    logic [CRC_W-1:0] crc_step;
    logic             fb;

    always_comb begin
        fb       = crc_q[0] ^ dat_q[0];
        crc_step = {1'b0, crc_q[CRC_W-1:1]} ^ (fb ? POLY_W : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
            dat_q <= '0;
        end else begin
            if (seed_en) begin
                crc_q <= seed_val;
            end else if (shift_en) begin
                crc_q <= crc_step;
            end
            if (load_en) begin
                dat_q <= load_val;
            end else if (shift_en) begin
                dat_q <= {1'b0, dat_q[CRC_W-1:1]};
            end
        end
    end

endmodule

// File: rtl/auth_seq.sv
module auth_seq #(
    parameter int          CRC_W   = 32,
    parameter logic [31:0] POLY    = 32'hEDB88320,
    parameter int          N_SEC   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_reg,
    input  logic [7:0]               wr_data,
    output logic [$clog2(N_SEC)-1:0] sec_addr,
    input  logic [CRC_W-1:0]         sec_data,
    output logic [7:0]               result,
    output logic                     done,
    output logic                     busy
);
    import auth_pkg::*;

    localparam int IDX_W      = $clog2(N_SEC);
    localparam int CHAL_BYTES = CRC_W / 8;
    localparam int BIT_W      = $clog2(CRC_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CRC_W - 1);

    auth_state_e      state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic [7:0]       sel_q;
    logic [CRC_W-1:0] chal_q;
    logic [CRC_W-1:0] crc_q;
    logic             start;
    logic             seed_en, load_en, shift_en, finish_en;
    logic [CRC_W-1:0] load_val;
    logic [7:0]       result_q;
    logic             done_q;
    logic [7:0]       fold;

    auth_hostregs #(.CHAL_BYTES(CHAL_BYTES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_reg  (wr_reg),
        .wr_data (wr_data),
        .accept  (state_q == ST_IDLE),
        .sel_q   (sel_q),
        .chal_q  (chal_q),
        .start   (start)
    );

    auth_crc_unit #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed_en  (seed_en),
        .seed_val (sec_data),
        .load_en  (load_en),
        .load_val (load_val),
        .shift_en (shift_en),
        .crc_q    (crc_q)
    );

    // Byte fold of the final remainder
    always_comb begin
        fold = '0;
        for (int b = 0; b < CHAL_BYTES; b++) begin
            fold = fold ^ crc_q[b*8 +: 8];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = ST_LOAD;
            ST_LOAD:       state_d = ST_SHIFT_CHAL;
            ST_SHIFT_CHAL: if (bit_q == LAST_BIT) state_d = ST_FETCH_KEY;
            ST_FETCH_KEY:  state_d = ST_SHIFT_KEY;
            ST_SHIFT_KEY:  if (bit_q == LAST_BIT) state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        seed_en   = 1'b0;
        load_en   = 1'b0;
        shift_en  = 1'b0;
        finish_en = 1'b0;
        load_val  = sec_data;
        sec_addr  = sel_q[IDX_W-1:0];
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE:       busy = 1'b0;
            ST_LOAD: begin
                seed_en  = 1'b1;
                load_en  = 1'b1;
                load_val = chal_q;
            end
            ST_SHIFT_CHAL: shift_en = 1'b1;
            ST_FETCH_KEY: begin
                sec_addr = sel_q[2*IDX_W-1:IDX_W];
                load_en  = 1'b1;
            end
            ST_SHIFT_KEY:  shift_en = 1'b1;
            ST_FINISH:     finish_en = 1'b1;
            default:       busy = 1'b0;
        endcase
    end

    // Bit counter, result and done
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            if (load_en) begin
                bit_q <= '0;
            end else if (shift_en) begin
                bit_q <= bit_q + 1'b1;
            end
            if (start) begin
                done_q <= 1'b0;
            end else if (finish_en) begin
                done_q   <= 1'b1;
                result_q <= fold;
            end
        end
    end

    assign result = result_q;
    assign done   = done_q;

endmodule

// File: rtl/auth_seq_chk.sv
module auth_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_reg,
    input logic       busy,
    input logic       done,
    input logic [7:0] result,
    input logic [7:0] sel_q
);

    // R3: busy only rises after a challenge write
    a_r3_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_reg));

    // R6: done appears exactly when busy falls
    a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    // R6: done and busy are exclusive
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R7: result is held during the computation
    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(result)));

    // R8: selection ignored while busy
    a_r8_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sel_q));

endmodule

bind auth_seq auth_seq_chk u_auth_seq_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_reg (wr_reg),
    .busy   (busy),
    .done   (done),
    .result (result),
    .sel_q  (sel_q)
);

// File: tb/auth_seq_bench.sv
`timescale 1ns/1ps
module auth_seq_bench;

    localparam logic [31:0] POLY = 32'hEDB88320;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_reg = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  sec_addr;
    logic [31:0] sec_data;
    logic [7:0]  result;
    logic        done;
    logic        busy;

    logic [31:0] mem [4];
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    always_comb sec_data = mem[sec_addr];

    auth_seq u_auth_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_data(wr_data), .sec_addr(sec_addr), .sec_data(sec_data),
        .result(result), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [31:0] seed, input logic [31:0] chal,
                                         input logic [31:0] key);
        logic [31:0] c;
        logic b;
        c = seed;
        for (int i = 0; i < 64; i++) begin
            b = (i < 32) ? chal[i] : key[i-32];
            if (c[0] ^ b) c = (c >> 1) ^ POLY;
            else          c = c >> 1;
        end
        return c[7:0] ^ c[15:8] ^ c[23:16] ^ c[31:24];
    endfunction

    task automatic wr(input logic r, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_reg = r; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input logic [31:0] chal, input logic [7:0] sel, input bit disturb);
        logic [7:0] prev;
        logic [7:0] exp;
        int n;
        bit held;
        prev = result;
        held = 1'b1;
        exp  = model(mem[sel[1:0]], chal, mem[sel[3:2]]);
        for (int k = 0; k < 3; k++) wr(1'b1, chal[k*8 +: 8]);
        check(busy == 1'b0, "R3 busy low before fourth byte", 32'(busy), 0);
        @(negedge clk);
        wr_en = 1'b1; wr_reg = 1'b1; wr_data = chal[31:24];
        @(negedge clk);
        wr_en = 1'b0;
        n = 1;
        check(busy == 1'b1, "R3 busy after fourth byte", 32'(busy), 1);
        check(done == 1'b0, "R3 done cleared at start", 32'(done), 0);
        check(sec_addr == sel[1:0], "R10 seed index in LOAD", 32'(sec_addr), 32'(sel[1:0]));
        while (busy && n < 200) begin
            @(negedge clk);
            if (busy) begin
                n++;
                if (result != prev) held = 1'b0;
                if (n == 34)
                    check(sec_addr == sel[3:2], "R10 key index in FETCH", 32'(sec_addr), 32'(sel[3:2]));
                if (disturb && n == 10) begin
                    wr_en = 1'b1; wr_reg = 1'b0; wr_data = ~sel;
                end
                if (disturb && n == 11) begin
                    wr_reg = 1'b1; wr_data = 8'h5A;
                end
                if (disturb && n == 12) wr_en = 1'b0;
            end
        end
        check(held, "R7 result held while busy", 32'(result), 32'(prev));
        check(n == 67, "R6 busy length", n, 67);
        check(done == 1'b1, "R6 done after finish", 32'(done), 1);
        check(result == exp, "R4 R5 result code", 32'(result), 32'(exp));
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] pats [3];
        mem[0] = 32'h1234_5678;
        mem[1] = 32'hDEAD_BEEF;
        mem[2] = 32'h0F0F_A5C3;
        mem[3] = 32'h8000_0001;
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hA1B2_C3D4;
        pats[2] = 32'hFFFF_FFFF;

        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy at reset", 32'(busy), 0);
        check(done == 1'b0, "R1 done at reset", 32'(done), 0);
        check(result == 8'h00, "R1 result at reset", 32'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5: sweep every seed/key index pair, upper nibble as noise
        for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 3; p++) begin
                wr(1'b0, 8'((s << 4) | s) ^ 8'h30);
                run(pats[p] ^ 32'(s * 32'h0101_0101), 8'(s), 1'b0);
            end
        end

        // R8: writes during busy are dropped; selection stays 4'h9
        wr(1'b0, 8'h09);
        run(32'h1357_9BDF, 8'h09, 1'b1);
        run(32'h2468_ACE0, 8'h09, 1'b0);

        // R9: selection write restarts the byte count
        wr(1'b1, 8'hEE);
        wr(1'b1, 8'hDD);
        wr(1'b0, 8'h06);
        run(32'hCAFE_0042, 8'h06, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule